// File: doc/BRIEF.md
# Store Buffer with Load Bypass

This block sits between a processor's memory-request port and a single-ported memory. Stores from the processor go into a small first-in first-out buffer and are written to memory later, in the order they arrived. Loads do not wait behind them. Each incoming load address is compared with every valid buffered store. If one or more entries match, the data of the youngest matching store answers the load and memory is not touched. If nothing matches, the load goes to memory at once and takes the port ahead of any store that is waiting to drain. A load can therefore complete before older stores to other addresses. This is store-to-load reordering.

A three-state controller makes the decisions. In `ST_IDLE` the memory port either carries a missing load, when one is accepted in that cycle, or the oldest buffered store. An accepted load that misses moves the controller to `ST_LD_ISSUE` if memory refuses the request, or straight to `ST_LD_WAIT` if memory takes it. From `ST_LD_ISSUE` the controller moves to `ST_LD_WAIT` on the memory handshake. From `ST_LD_WAIT` it returns to `ST_IDLE` when memory returns read data. Stores can be accepted in every state while the buffer has room. Only one memory load can be outstanding at a time.

Top module: `stbuf_bypass`

## Requirements
- R1: After reset, `empty` is 1 and both `rsp_valid` and `mem_valid` are 0.
- R2: A store (`req_is_load`=0) is accepted whenever the buffer is not full, and it is held in the buffer until memory accepts it.
- R3: When DEPTH stores are pending, `req_ready` is 0 for a store request and 1 for a load request in `ST_IDLE`.
- R4: Buffered stores reach memory strictly in acceptance order, one per memory handshake, with `mem_we`=1. Each one carries the address and data it was accepted with.
- R5: A load whose address matches a buffered store gets the data of the youngest matching store. `rsp_valid` is 1 in the cycle after the load is accepted, and no memory read is made.
- R6: A load with no match drives `mem_valid`=1, `mem_we`=0 and its own address in the same cycle it is accepted, even while stores are pending. `rsp_valid` rises, carrying `mem_rdata`, one cycle after `mem_rvalid`.
- R7: A memory load completes while older stores to other addresses are still buffered. No store drains between the acceptance of a missing load and its response.
- R8: While a memory load is outstanding (`ST_LD_ISSUE` or `ST_LD_WAIT`), `req_ready` is 0 for loads.
- R9: `empty` is 1 exactly when no stores are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_is_load | input | 1 | 1 = load, 0 = store |
| req_addr | input | ADDR_W | Request word address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Load response pulse |
| rsp_data | output | DATA_W | Load response data |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DATA_W | Memory read data |
| empty | output | 1 | No stores pending |

## Verification
Each result has a fixed due cycle:
- A buffer-hit response is due at the first falling edge after the accepting rising edge.
- With a memory that answers one cycle after its handshake, a missing load's response is due at the second falling edge after acceptance.
- The memory-port choice for a missing load is combinational, so it is checked just after the inputs change, before the accepting edge.

The bench drives inputs on falling edges and samples only there. It counts falling edges between acceptance and response and compares that count with the due cycle. The bench keeps its own log of memory writes and its own list of expected writes, and compares the two after every drain.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_LD_ISSUE = 2'd1,
        ST_LD_WAIT  = 2'd2
    } ctrl_state_t;

endpackage

// File: rtl/stbuf_fifo.sv
module stbuf_fifo #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              full,
    output logic              empty,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] slot_addr [DEPTH];
    logic [DATA_W-1:0] slot_data [DEPTH];
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  wr_ptr;
    logic [CNT_W-1:0]  count;
    logic [DEPTH-1:0]  slot_live;
    logic [DEPTH-1:0]  slot_match;

    assign full      = (int'(count) == DEPTH);
    assign empty     = (count == '0);
    assign head_addr = slot_addr[rd_ptr];
    assign head_data = slot_data[rd_ptr];

    // per-slot storage and address comparator
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && (int'(wr_ptr) == i)) begin
                slot_addr[i] <= push_addr;
                slot_data[i] <= push_data;
            end
        end

        always_comb begin
            slot_live[i]  = (((i - int'(rd_ptr) + DEPTH) % DEPTH) < int'(count));
            slot_match[i] = slot_live[i] && (slot_addr[i] == look_addr);
        end
    end

    // walk from oldest to youngest; the last match seen is the youngest
    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (slot_match[(int'(rd_ptr) + k) % DEPTH]) begin
                look_hit  = 1'b1;
                look_data = slot_data[(int'(rd_ptr) + k) % DEPTH];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (int'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (int'(rd_ptr) == DEPTH - 1) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty)); // R4
    AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> !empty); // R2
    AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full)); // R9

endmodule

// File: rtl/stbuf_ctrl.sv
module stbuf_ctrl
    import stbuf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_load,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              push,
    output logic              pop,
    input  logic              buf_full,
    input  logic              buf_empty,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [DATA_W-1:0] head_data,
    input  logic              hit,
    input  logic [DATA_W-1:0] hit_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    ctrl_state_t       state_q;
    ctrl_state_t       state_d;
    logic [ADDR_W-1:0] ld_addr_q;
    logic              ld_acc;
    logic              st_acc;
    logic              drain;

    assign ld_acc = req_valid && req_is_load && (state_q == ST_IDLE);
    assign st_acc = req_valid && !req_is_load && !buf_full;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ld_acc && !hit) begin
                    state_d = mem_ready ? ST_LD_WAIT : ST_LD_ISSUE;
                end
            end
            ST_LD_ISSUE: begin
                if (mem_ready) begin
                    state_d = ST_LD_WAIT;
                end
            end
            ST_LD_WAIT: begin
                if (mem_rvalid) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs: request handshake and memory port arbitration
    always_comb begin
        req_ready = req_is_load ? (state_q == ST_IDLE) : !buf_full;
        push      = st_acc;
        drain     = 1'b0;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (ld_acc && !hit) begin
                    mem_valid = 1'b1;
                    mem_addr  = req_addr;
                end else if (!buf_empty) begin
                    drain     = 1'b1;
                    mem_valid = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = head_addr;
                    mem_wdata = head_data;
                end
            end
            ST_LD_ISSUE: begin
                mem_valid = 1'b1;
                mem_addr  = ld_addr_q;
            end
            ST_LD_WAIT: begin
                mem_valid = 1'b0;
            end
            default: mem_valid = 1'b0;
        endcase
        pop = drain && mem_ready;
    end

    // registered load response and captured load address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            ld_addr_q <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (ld_acc) begin
                ld_addr_q <= req_addr;
            end
            if (ld_acc && hit) begin
                rsp_valid <= 1'b1;
                rsp_data  <= hit_data;
            end else if ((state_q == ST_LD_WAIT) && mem_rvalid) begin
                rsp_valid <= 1'b1;
                rsp_data  <= mem_rdata;
            end
        end
    end

    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_acc && hit) |=> rsp_valid); // R5
    AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_acc && hit) |-> !(mem_valid && !mem_we)); // R5
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_acc && !hit) |-> (mem_valid && !mem_we && !pop)); // R6
    AST_MISS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LD_WAIT) && mem_rvalid) |=> (rsp_valid && (state_q == ST_IDLE))); // R6
    AST_NO_DRAIN_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !pop); // R7
    AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && req_valid && req_is_load) |-> !req_ready); // R8

endmodule

// File: rtl/stbuf_bypass.sv
module stbuf_bypass #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_load,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              empty
);

    logic              push;
    logic              pop;
    logic              buf_full;
    logic              buf_empty;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic              hit;
    logic [DATA_W-1:0] hit_data;

    assign empty = buf_empty;

    stbuf_fifo #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (req_addr),
        .push_data (req_wdata),
        .pop       (pop),
        .head_addr (head_addr),
        .head_data (head_data),
        .full      (buf_full),
        .empty     (buf_empty),
        .look_addr (req_addr),
        .look_hit  (hit),
        .look_data (hit_data)
    );

    stbuf_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_is_load (req_is_load),
        .req_addr    (req_addr),
        .req_ready   (req_ready),
        .push        (push),
        .pop         (pop),
        .buf_full    (buf_full),
        .buf_empty   (buf_empty),
        .head_addr   (head_addr),
        .head_data   (head_data),
        .hit         (hit),
        .hit_data    (hit_data),
        .mem_valid   (mem_valid),
        .mem_ready   (mem_ready),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data)
    );

    AST_DRAIN_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> !empty); // R4
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (empty && !rsp_valid)); // R1

endmodule

// File: tb/stbuf_bypass_test.sv
`timescale 1ns/1ps
module stbuf_bypass_test;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_is_load = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          empty;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] model [256];
    logic [AW-1:0] log_addr [64];
    logic [DW-1:0] log_data [64];
    int            log_n = 0;
    logic [AW-1:0] exp_addr [64];
    logic [DW-1:0] exp_data [64];
    int            exp_n = 0;
    int            rd_cnt = 0;

    always #4 clk = ~clk;

    stbuf_bypass #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_is_load(req_is_load),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .empty(empty)
    );

    // memory model: writes land at the handshake, read data one cycle later
    initial begin
        for (int i = 0; i < 256; i++) model[i] = DW'(i * 3 + 1);
    end

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_valid && mem_ready) begin
            if (mem_we) begin
                model[mem_addr] <= mem_wdata;
                if (log_n < 64) begin
                    log_addr[log_n] <= mem_addr;
                    log_data[log_n] <= mem_wdata;
                end
                log_n <= log_n + 1;
            end else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= model[mem_addr];
                rd_cnt     <= rd_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_is_load = 1'b0; req_addr = a; req_wdata = d;
        #1;
        for (int w = 0; w < 50 && !req_ready; w++) begin
            @(negedge clk); #1;
        end
        check("R2 store accepted", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_n < 64) begin
            exp_addr[exp_n] = a;
            exp_data[exp_n] = d;
        end
        exp_n++;
    endtask

    task automatic load_hit(input logic [AW-1:0] a, input logic [DW-1:0] e);
        int rd_before;
        rd_before = rd_cnt;
        req_valid = 1'b1; req_is_load = 1'b1; req_addr = a;
        #1;
        check("R5 load ready", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R5 hit response one cycle later", 32'(rsp_valid), 32'd1);
        check("R5 youngest matching data", 32'(rsp_data), 32'(e));
        @(negedge clk);
        check("R5 no memory read on hit", 32'(rd_cnt - rd_before), 32'd0);
    endtask

    task automatic load_miss(input logic [AW-1:0] a, input logic [DW-1:0] e, input bit with_pending);
        int log_before;
        int wait_n;
        log_before = log_n;
        req_valid = 1'b1; req_is_load = 1'b1; req_addr = a;
        mem_ready = 1'b1;
        #1;
        check("R6 load drives memory", 32'(mem_valid), 32'd1);
        check("R6 load is a read", 32'(mem_we), 32'd0);
        check("R6 load address", 32'(mem_addr), 32'(a));
        @(negedge clk);
        #1;
        check("R8 second load refused", 32'(req_ready), 32'd0);
        req_valid = 1'b0;
        wait_n = 1;
        while (!rsp_valid && wait_n < 20) begin
            @(negedge clk);
            wait_n++;
        end
        check("R6 miss response at second falling edge", 32'(wait_n), 32'd2);
        check("R6 miss data from memory", 32'(rsp_data), 32'(e));
        if (with_pending) begin
            check("R7 no store drained during load", 32'(log_n - log_before), 32'd0);
            check("R7 stores still pending", 32'(empty), 32'd0);
        end
    endtask

    task automatic drain_all();
        mem_ready = 1'b1;
        for (int w = 0; w < 40 && !empty; w++) @(negedge clk);
        @(negedge clk);
        check("R9 empty after drain", 32'(empty), 32'd1);
        check("R4 write count", 32'(log_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < 64; i++) begin
            check("R4 drain order address", 32'(log_addr[i]), 32'(exp_addr[i]));
            check("R4 drain order data", 32'(log_data[i]), 32'(exp_data[i]));
        end
        mem_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 empty after reset", 32'(empty), 32'd1);
        check("R1 no response after reset", 32'(rsp_valid), 32'd0);
        check("R1 memory idle after reset", 32'(mem_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep: youngest hit, miss overtaking pending stores, ordered drain
        for (int s = 0; s < 8; s++) begin
            logic [AW-1:0] a;
            logic [AW-1:0] b;
            logic [AW-1:0] m;
            logic [DW-1:0] v1;
            logic [DW-1:0] v2;
            a  = AW'(s * 9 + 2);
            b  = a ^ AW'(1);
            m  = AW'(s * 5 + 130);
            v1 = DW'(16'h1000 + s * 17);
            v2 = DW'(16'h2000 + s * 29);
            mem_ready = 1'b0;
            push_store(a, v1);
            push_store(b, v1 ^ 16'h00ff);
            push_store(a, v2);
            check("R9 empty low with pending stores", 32'(empty), 32'd0);
            check("R2 stores held without handshake", 32'(log_n), 32'(exp_n - 3));
            load_hit(a, v2);
            load_hit(b, v1 ^ 16'h00ff);
            load_miss(m, DW'(int'(m) * 3 + 1), 1'b1);
            drain_all();
            load_miss(a, v2, 1'b0);
            @(negedge clk);
        end

        // full buffer: stores stall, loads accepted
        mem_ready = 1'b0;
        for (int i = 0; i < DEPTH; i++) push_store(AW'(200 + i), DW'(16'h5a00 + i));
        req_valid = 1'b1; req_is_load = 1'b0; req_addr = 8'd250; req_wdata = 16'h7777;
        #1;
        check("R3 store stalled when full", 32'(req_ready), 32'd0);
        req_is_load = 1'b1; req_addr = 8'd203;
        #1;
        check("R3 load accepted when full", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R3 load on full buffer hits", 32'(rsp_data), 32'h5a03);
        drain_all();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule